// File: doc/BRIEF.md
# 10BASE-T Link Integrity Monitor

This block keeps the pass/fail state of a 10BASE-T twisted-pair link and generates the idle link test pulses the transmitter sends. It watches two inputs. One is a receive-carrier flag from the squelch logic. The other is a single-cycle strobe that marks each received link pulse, already qualified by the analog front end. When neither has been seen for a loss timeout, the block declares the link failed. While the link is failed, the transmit, receive and collision paths are all shut. The link comes back when receive carrier returns, or when enough link pulses arrive back to back at a plausible spacing.

A separate pulse generator asks the line driver for a link test pulse at a fixed period whenever transmit is idle. It keeps doing so whether the link has passed or failed, and also when link checking is strapped off. With the strap asserted, the link is reported as passing and every path stays open, whatever arrives on the receive pair. All timing is counted in cycles of one fixed system clock, and every interval is a parameter.

Top module: `lnk_integrity_mon`

## Requirements
- R1: While `rst_ni` is low, `link_ok_o` equals `chk_disable_i`, `lp_req_o` is 0 and the internal state is link fail. After `rst_ni` rises, the link stays failed until one of the events in R3 or R4 occurs.
- R2: While `link_ok_o` is 0, the outputs `tx_en_o`, `rx_en_o`, `col_en_o` and `rx_status_o` are all 0 and `link_stat_no` is 1. While `link_ok_o` is 1, the three enables are 1 and `link_stat_no` is 0.
- R3: A cycle with `rx_carrier_i` high while the link is failed brings the link to pass at the next clock edge.
- R4: `PASS_PULSES` consecutive link pulse strobes received during link fail bring the link to pass at the edge that samples the last of them.
- R5: A strobe that arrives fewer than `MIN_GAP` cycles after the previous strobe restarts the consecutive count at one. The spacing is measured from edge to edge.
- R6: The link drops from pass to fail on the edge that samples the `LOSS_CYCLES`-th consecutive cycle with neither carrier nor strobe. In link fail, the same timeout clears any partial strobe count.
- R7: While `chk_disable_i` is high, `link_ok_o` is 1 in the same cycle and stays 1 regardless of receive activity. After the strap is released, the link starts in pass with a fresh loss timer.
- R8: While `tx_active_i` is low, `lp_req_o` goes high for `LP_WIDTH` cycles once every `LP_PERIOD` cycles. This happens regardless of the link state and of the strap. The first request after reset begins `LP_PERIOD` cycles after reset release.
- R9: `lp_req_o` is 0 in any cycle in which `tx_active_i` is high. After transmit activity ends, the next request starts `LP_PERIOD` cycles after the last active cycle.
- R10: `rx_status_o` is high only when `rx_carrier_i` is high and `link_ok_o` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, the time base for every interval |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_carrier_i | input | 1 | Valid receive data present on the twisted pair |
| rx_lp_strobe_i | input | 1 | One-cycle strobe per qualified received link pulse |
| tx_active_i | input | 1 | Transmit data in progress |
| chk_disable_i | input | 1 | Strap that turns link checking off |
| link_ok_o | output | 1 | Link pass flag |
| link_stat_no | output | 1 | Active-low link status, low on pass |
| tx_en_o | output | 1 | Enable for the transmit data path |
| rx_en_o | output | 1 | Enable for the receive data path |
| col_en_o | output | 1 | Enable for collision detection |
| rx_status_o | output | 1 | Receive status, suppressed during link fail |
| lp_req_o | output | 1 | Request to the driver to send an idle link pulse |

## Verification
The bound checker checks several properties on every clock:
- a fail state closes all three paths and raises the active-low status;
- the strap forces a pass;
- receive carrier always yields pass on the next cycle;
- every rise or fall of the link flag has a legal cause (activity for a rise, silence for a drop);
- a pulse request is never followed at once by another, and none starts in the first idle cycle after a transmission.

The exact timing can only be shown by the bench's scenarios, which compare against a cycle-by-cycle model. This covers the edge at which the loss timeout fires, the count of strobes and the spacing that resets it, the timeout clearing a partial count, and the period and width of the pulse requests across transmit bursts and strap changes.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

   typedef enum logic {
      LNK_DOWN = 1'b0,
      LNK_UP   = 1'b1
   } lnk_state_e;

   // bits needed to hold values 0..max_val
   function automatic int unsigned cnt_w(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/lnk_loss_timer.sv
module lnk_loss_timer
   import lnk_pkg::*;
#(
   parameter int unsigned LOSS_CYCLES = 20_000_000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic hold_i,
   input  logic act_i,
   output logic expire_o
);

   localparam int unsigned W = cnt_w(LOSS_CYCLES);
   localparam logic [W-1:0] LIM = W'(LOSS_CYCLES - 1);

   if (LOSS_CYCLES < 2) begin : g_bad_loss
      $error("lnk_loss_timer: LOSS_CYCLES must be at least 2");
   end

   logic [W-1:0] idle_q;

   // consecutive silent cycles, saturating at the limit
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         idle_q <= '0;
      end else if (hold_i || act_i) begin
         idle_q <= '0;
      end else if (idle_q != LIM) begin
         idle_q <= idle_q + W'(1);
      end
   end

   // true on the silent cycle that completes the timeout (and after)
   assign expire_o = !act_i && !hold_i && (idle_q == LIM);

endmodule

// File: rtl/lnk_pulse_run.sv
module lnk_pulse_run
   import lnk_pkg::*;
#(
   parameter int unsigned PASS_PULSES = 3,
   parameter int unsigned MIN_GAP     = 400_000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic gap_hold_i,
   input  logic run_clr_i,
   input  logic restart_i,
   input  logic strobe_i,
   output logic done_o
);

   localparam bit           USE_GAP  = (MIN_GAP >= 2);
   localparam int unsigned  GAP_MAX  = USE_GAP ? (MIN_GAP - 1) : 1;
   localparam int unsigned  GW       = cnt_w(GAP_MAX);
   localparam logic [GW-1:0] GLIM    = GW'(GAP_MAX);
   localparam int unsigned  RW       = cnt_w(PASS_PULSES);
   localparam logic [RW-1:0] RLIM    = RW'(PASS_PULSES);

   if (PASS_PULSES < 1) begin : g_bad_pass
      $error("lnk_pulse_run: PASS_PULSES must be at least 1");
   end

   logic [GW-1:0] gap_q;
   logic          too_close;
   logic [RW-1:0] run_q;
   logic [RW-1:0] run_nx;

   // cycles since the last strobe; saturated value means "far enough"
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gap_q <= GLIM;
      end else if (gap_hold_i) begin
         gap_q <= GLIM;
      end else if (strobe_i) begin
         gap_q <= '0;
      end else if (gap_q != GLIM) begin
         gap_q <= gap_q + GW'(1);
      end
   end

   assign too_close = USE_GAP && (gap_q != GLIM);
   assign run_nx    = too_close ? RW'(1) : (run_q + RW'(1));
   assign done_o    = strobe_i && (run_nx >= RLIM);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= '0;
      end else if (run_clr_i || restart_i) begin
         run_q <= '0;
      end else if (strobe_i) begin
         run_q <= done_o ? '0 : run_nx;
      end
   end

endmodule

// File: rtl/lnk_idle_pulser.sv
module lnk_idle_pulser
   import lnk_pkg::*;
#(
   parameter int unsigned LP_PERIOD = 3_200_000,
   parameter int unsigned LP_WIDTH  = 20
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tx_busy_i,
   output logic lp_req_o
);

   localparam int unsigned   PW   = cnt_w(LP_PERIOD - 1);
   localparam logic [PW-1:0] PLIM = PW'(LP_PERIOD - 1);

   if (LP_WIDTH < 1) begin : g_bad_width
      $error("lnk_idle_pulser: LP_WIDTH must be at least 1");
   end
   if (LP_PERIOD < LP_WIDTH + 2) begin : g_bad_period
      $error("lnk_idle_pulser: LP_PERIOD must exceed LP_WIDTH by 2 or more");
   end

   logic [PW-1:0] per_q;
   logic          fire;
   logic          active;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         per_q <= '0;
      end else if (tx_busy_i || (per_q == PLIM)) begin
         per_q <= '0;
      end else begin
         per_q <= per_q + PW'(1);
      end
   end

   assign fire = !tx_busy_i && (per_q == PLIM);

   if (LP_WIDTH == 1) begin : g_single
      logic req_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            req_q <= 1'b0;
         end else begin
            req_q <= fire;
         end
      end
      assign active = req_q;
   end else begin : g_multi
      localparam int unsigned   LW = cnt_w(LP_WIDTH);
      logic [LW-1:0] left_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            left_q <= '0;
         end else if (tx_busy_i) begin
            left_q <= '0;
         end else if (fire) begin
            left_q <= LW'(LP_WIDTH);
         end else if (left_q != '0) begin
            left_q <= left_q - LW'(1);
         end
      end
      assign active = (left_q != '0);
   end

   assign lp_req_o = active && !tx_busy_i;

endmodule

// File: rtl/lnk_integrity_mon.sv
module lnk_integrity_mon
   import lnk_pkg::*;
#(
   parameter int unsigned LOSS_CYCLES = 20_000_000,
   parameter int unsigned LP_PERIOD   = 3_200_000,
   parameter int unsigned MIN_GAP     = 400_000,
   parameter int unsigned PASS_PULSES = 3,
   parameter int unsigned LP_WIDTH    = 20
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rx_carrier_i,
   input  logic rx_lp_strobe_i,
   input  logic tx_active_i,
   input  logic chk_disable_i,
   output logic link_ok_o,
   output logic link_stat_no,
   output logic tx_en_o,
   output logic rx_en_o,
   output logic col_en_o,
   output logic rx_status_o,
   output logic lp_req_o
);

   lnk_state_e state_q;
   logic       rx_act;
   logic       loss_exp;
   logic       run_done;
   logic       link_ok;

   assign rx_act = rx_carrier_i || rx_lp_strobe_i;

   lnk_loss_timer #(
      .LOSS_CYCLES (LOSS_CYCLES)
   ) u_loss (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hold_i   (chk_disable_i),
      .act_i    (rx_act),
      .expire_o (loss_exp)
   );

   lnk_pulse_run #(
      .PASS_PULSES (PASS_PULSES),
      .MIN_GAP     (MIN_GAP)
   ) u_run (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .gap_hold_i (chk_disable_i),
      .run_clr_i  (chk_disable_i || (state_q == LNK_UP)),
      .restart_i  (loss_exp),
      .strobe_i   (rx_lp_strobe_i),
      .done_o     (run_done)
   );

   lnk_idle_pulser #(
      .LP_PERIOD (LP_PERIOD),
      .LP_WIDTH  (LP_WIDTH)
   ) u_pulser (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tx_busy_i (tx_active_i),
      .lp_req_o  (lp_req_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= LNK_DOWN;
      end else if (chk_disable_i) begin
         state_q <= LNK_UP;
      end else begin
         case (state_q)
            LNK_UP:   if (loss_exp) state_q <= LNK_DOWN;
            LNK_DOWN: if (rx_carrier_i || run_done) state_q <= LNK_UP;
            default:  state_q <= LNK_DOWN;
         endcase
      end
   end

   assign link_ok      = (state_q == LNK_UP) || chk_disable_i;
   assign link_ok_o    = link_ok;
   assign link_stat_no = !link_ok;
   assign tx_en_o      = link_ok;
   assign rx_en_o      = link_ok;
   assign col_en_o     = link_ok;
   assign rx_status_o  = rx_carrier_i && link_ok;

endmodule

// File: rtl/lnk_integrity_mon_chk.sv
module lnk_integrity_mon_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic rx_carrier_i,
   input logic rx_lp_strobe_i,
   input logic tx_active_i,
   input logic chk_disable_i,
   input logic link_ok_o,
   input logic link_stat_no,
   input logic tx_en_o,
   input logic rx_en_o,
   input logic col_en_o,
   input logic rx_status_o,
   input logic lp_req_o
);

   // R1: reset holds the request low and reports only the strap
   a_r1_reset_quiet: assert property (@(posedge clk_i)
      !rst_ni |-> (!lp_req_o && (link_ok_o == chk_disable_i)));

   // R2: a failed link closes every path
   a_r2_fail_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !link_ok_o |-> (!tx_en_o && !rx_en_o && !col_en_o && link_stat_no && !rx_status_o));

   // R3: receive carrier always yields pass one cycle later
   a_r3_carrier_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_carrier_i |=> link_ok_o);

   // R4: pass only rises after activity or with the strap
   a_r4_rise_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(link_ok_o) |-> ($past(rx_carrier_i) || $past(rx_lp_strobe_i) || chk_disable_i));

   // R6: a drop to fail follows a silent cycle or strap release
   a_r6_drop_needs_silence: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(link_ok_o) |-> ($past(!rx_carrier_i && !rx_lp_strobe_i) || $past(chk_disable_i)));

   // R7: the strap forces pass with paths open
   a_r7_strap_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chk_disable_i |-> (link_ok_o && tx_en_o && rx_en_o));

   // R8: requests are separated by at least one idle cycle
   a_r8_req_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(lp_req_o) |=> !lp_req_o);

   // R9: no request in the first idle cycle after transmit
   a_r9_restart_after_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(tx_active_i) && !tx_active_i) |-> !lp_req_o);

   // R10: receive status needs carrier and pass
   a_r10_status_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_status_o |-> (rx_carrier_i && link_ok_o));

endmodule

bind lnk_integrity_mon lnk_integrity_mon_chk u_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .rx_carrier_i   (rx_carrier_i),
   .rx_lp_strobe_i (rx_lp_strobe_i),
   .tx_active_i    (tx_active_i),
   .chk_disable_i  (chk_disable_i),
   .link_ok_o      (link_ok_o),
   .link_stat_no   (link_stat_no),
   .tx_en_o        (tx_en_o),
   .rx_en_o        (rx_en_o),
   .col_en_o       (col_en_o),
   .rx_status_o    (rx_status_o),
   .lp_req_o       (lp_req_o)
);

// File: tb/sim_lnk_integrity_mon.sv
`timescale 1ns/1ps
module sim_lnk_integrity_mon;

   localparam int LOSS  = 200;
   localparam int PER   = 64;
   localparam int GAP   = 20;
   localparam int NPASS = 3;
   localparam int WID   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic carrier = 1'b0, strobe = 1'b0, tx = 1'b0, strap = 1'b0;
   logic link_ok, stat_n, tx_en, rx_en, col_en, rx_stat, lp_req;

   int vectors = 0;
   int miscompares = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   lnk_integrity_mon #(
      .LOSS_CYCLES (LOSS), .LP_PERIOD (PER), .MIN_GAP (GAP),
      .PASS_PULSES (NPASS), .LP_WIDTH (WID)
   ) u0 (
      .clk_i (clk), .rst_ni (rst_n), .rx_carrier_i (carrier),
      .rx_lp_strobe_i (strobe), .tx_active_i (tx), .chk_disable_i (strap),
      .link_ok_o (link_ok), .link_stat_no (stat_n), .tx_en_o (tx_en),
      .rx_en_o (rx_en), .col_en_o (col_en), .rx_status_o (rx_stat),
      .lp_req_o (lp_req)
   );

   // ---------------- behavioural reference model ----------------
   int  cyc, last_act, last_lp, run, last_ref, req_left, n_idle;
   bit  lp_seen, m_pass, act, close;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc = 0; last_act = -1; last_lp = 0; lp_seen = 0; run = 0;
         m_pass = 0; last_ref = -1; req_left = 0;
      end else begin
         if (strap) begin
            m_pass = 1; run = 0; last_act = cyc; lp_seen = 0;
         end else begin
            act    = carrier || strobe;
            n_idle = act ? 0 : (cyc - last_act);
            close  = strobe && lp_seen && ((cyc - last_lp) < GAP);
            if (m_pass) begin
               if (!act && n_idle >= LOSS) m_pass = 0;
               run = 0;
            end else if (carrier) begin
               m_pass = 1; run = 0;
            end else if (strobe) begin
               run = close ? 1 : run + 1;
               if (run >= NPASS) begin m_pass = 1; run = 0; end
            end else if (n_idle >= LOSS) begin
               run = 0;
            end
            if (act) last_act = cyc;
            if (strobe) begin last_lp = cyc; lp_seen = 1; end
         end
         if (tx) begin
            last_ref = cyc; req_left = 0;
         end else if (cyc - last_ref == PER) begin
            last_ref = cyc; req_left = WID;
         end else if (req_left > 0) begin
            req_left = req_left - 1;
         end
         cyc = cyc + 1;
      end
   end

   task automatic cmp(input string req, input logic a, input logic e, input string what);
      if (a !== e) begin
         miscompares++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, a, e, $time);
      end
   endtask

   always @(negedge clk) begin
      logic e_ok;
      e_ok = m_pass || strap;
      vectors++;
      cmp(cur_req, link_ok, e_ok, "link_ok");
      cmp("R2", stat_n, !e_ok, "link_stat_n");
      cmp("R2", tx_en, e_ok, "tx_en");
      cmp("R2", rx_en, e_ok, "rx_en");
      cmp("R2", col_en, e_ok, "col_en");
      cmp("R10", rx_stat, carrier && e_ok, "rx_status");
      cmp("R8", lp_req, (req_left > 0) && !tx, "lp_req");
   end

   // ---------------- directed checks ----------------
   task automatic chk(input string req, input int a, input int e);
      vectors++;
      if (a != e) begin
         miscompares++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, a, e, $time);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic lp_pulse();
      strobe = 1'b1;
      tick(1);
      strobe = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #1 rst_n = 1'b0;
      tick(4);
      cur_req = "R1";
      chk("R1 link_ok in reset", link_ok, 0);
      chk("R1 status_n in reset", stat_n, 1);
      chk("R1 lp_req in reset", lp_req, 0);
      rst_n = 1'b1;
      tick(1);
      chk("R1 fail after reset", link_ok, 0);

      // R4: three well spaced pulses
      cur_req = "R4";
      lp_pulse(); tick(29); lp_pulse(); tick(29);
      chk("R4 two pulses not enough", link_ok, 0);
      chk("r2_ closed in fail", tx_en, 0);
      lp_pulse();
      chk("R4 third pulse passes", link_ok, 1);
      chk("R2 status_n on pass", stat_n, 0);
      chk("R2 col_en on pass", col_en, 1);

      // R6: loss timeout
      cur_req = "R6";
      tick(LOSS - 5);
      chk("R6 still pass before timeout", link_ok, 1);
      tick(10);
      chk("R6 fail after timeout", link_ok, 0);
      chk("R2 rx_en closed", rx_en, 0);

      // R5: a close pulse restarts the count
      cur_req = "R5";
      lp_pulse(); tick(29); lp_pulse(); tick(9); lp_pulse(); tick(29); lp_pulse();
      chk("R5 close pulse restarted count", link_ok, 0);
      tick(29); lp_pulse();
      chk("R5 count completes after restart", link_ok, 1);

      // R6: timeout in fail clears a partial count
      cur_req = "R6";
      tick(LOSS + 10);
      lp_pulse(); tick(29); lp_pulse(); tick(LOSS + 20); lp_pulse();
      chk("R6 partial count cleared", link_ok, 0);
      tick(29); lp_pulse();
      chk("R6 second after clear", link_ok, 0);
      tick(29); lp_pulse();
      chk("R6 third after clear passes", link_ok, 1);

      // R3 and R10: carrier recovers the link
      cur_req = "R3";
      tick(LOSS + 10);
      carrier = 1'b1;
      #0.2;
      chk("R10 status suppressed in fail", rx_stat, 0);
      tick(1);
      chk("R3 carrier passes", link_ok, 1);
      chk("R10 status on pass", rx_stat, 1);
      tick(2);
      carrier = 1'b0;

      // R9: transmit suppresses and restarts pulses
      cur_req = "R9";
      tx = 1'b1;
      #0.2;
      chk("R9 no request during tx", lp_req, 0);
      tick(100);
      chk("R9 no request after long tx", lp_req, 0);
      tx = 1'b0;
      tick(63);
      chk("R9 no request before period", lp_req, 0);
      tick(1);
      chk("R8 request at period", lp_req, 1);

      // R7: strap forces pass, pulses continue
      cur_req = "R7";
      tick(LOSS + 10);
      chk("R7 failed before strap", link_ok, 0);
      strap = 1'b1;
      #0.2;
      chk("R7 strap passes at once", link_ok, 1);
      begin
         int rises = 0;
         logic prev = 1'b0;
         for (int i = 0; i < LOSS + 50; i++) begin
            tick(1);
            if (lp_req && !prev) rises++;
            prev = lp_req;
         end
         chk("R8 pulses continue under strap", (rises >= 3) ? 1 : 0, 1);
      end
      chk("R7 still pass under strap", link_ok, 1);
      strap = 1'b0;
      tick(LOSS - 5);
      chk("R7 pass with fresh timer", link_ok, 1);
      tick(10);
      chk("R7 timer runs after release", link_ok, 0);

      tick(5);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule